// File: doc/BRIEF.md
# Standby Power-State Sequencer

This block decides when a small microcontroller core sleeps and when it wakes. A one-cycle halt strobe parks the CPU clock while the main oscillator keeps running. A one-cycle stop strobe, accepted only while the core runs from the main clock, also turns the main oscillator off and raises a pull-up on the crystal output pin. Any other clock in the system is not controlled here. While the core is stopped, the external expansion bus and the port latches are held in fixed idle states.

Wake-up comes from the interrupt request flags and their mask bits. A source can wake the core when its flag is set and its mask bit is clear. A parameter vector selects which sources may also end a stop; by default source 0 cannot. Every exit from a stop goes through an oscillation-settling wait before the CPU clock returns. The length of that wait is picked by a 3-bit select. A stop strobe that arrives while a wake source is already live turns into a halt at once, and that halt still ends with the settling wait.

Top module: `stby_wake_ctrl`

## Requirements
- R1: Reset (synchronous, active high) gives mode RUN (code 0), `osc_en`=1, `cpu_clk_en`=1 and `xtal_pullup`=0. It releases every pin override: `pad_wr_n`=1, and all pads follow the CPU values again.
- R2: The `mode` codes are RUN=0, HALT=1, STOP=2 and WAIT_STABLE=3. In RUN, `halt_req` moves the block to HALT at the next edge. In HALT, `cpu_clk_en`=0 and `osc_en`=1.
- R3: In RUN, `stop_req` with `on_main_clk`=1 and no live source moves the block to STOP, with `osc_en`=0, `cpu_clk_en`=0 and `xtal_pullup`=1. With `on_main_clk`=0 the stop strobe is ignored. When both strobes come together, the stop strobe wins.
- R4: A halt entered through `halt_req` ends at the next edge after any source is live. A source is live when its `irq_flag` bit is 1 and its `irq_mask` bit is 0; source 0 counts. The block then returns to RUN with no settling wait.
- R5: STOP ends only when a live source is also enabled in `STOP_WAKE_MASK` (default: every bit except bit 0). It then moves to WAIT_STABLE. Masked sources and source 0 leave the block in STOP.
- R6: WAIT_STABLE lasts exactly 2^(`BASE_EXP`+2·`ost_sel`) cycles, using the `ost_sel` value sampled on entry. During the wait `osc_en`=1 and `cpu_clk_en`=0. After it the block is in RUN.
- R7: A stop strobe that would be accepted while any source is live moves the block to HALT instead, with `osc_en`=1 and `xtal_pullup`=0. That halt exits to WAIT_STABLE, not RUN.
- R8: While in STOP, `pad_ad_oe`=0 (data lines float), `pad_astb`=0, `pad_wr_n`=1, `pad_rd_n`=1, and `core_wait_n`=1 (the wait pin is ignored).
- R9: Outside STOP, each pad output equals its CPU input from one cycle earlier. In STOP, `pad_addr` and `pad_port` keep the values they had when the stop began.
- R10: Requests are ignored outside RUN. A stop strobe in HALT, or a stop or halt strobe in STOP or WAIT_STABLE, does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | Stop strobe from the instruction decoder |
| halt_req | input | 1 | Halt strobe from the instruction decoder |
| on_main_clk | input | 1 | 1 while the CPU runs from the main clock |
| ost_sel | input | SEL_W | Settling-wait select |
| irq_flag | input | NSRC | Interrupt request flags |
| irq_mask | input | NSRC | Interrupt mask bits (1 = masked) |
| cpu_ad_out | input | AD_W | CPU drive for the multiplexed address/data lines |
| cpu_ad_oe | input | 1 | CPU output enable for the address/data lines |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_astb | input | 1 | CPU address strobe |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_port | input | PORT_W | CPU port output latch values |
| pad_wait_n | input | 1 | External wait pin |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| xtal_pullup | output | 1 | Crystal output pin pull-up enable |
| mode | output | 2 | Current power mode |
| pad_ad_out | output | AD_W | Address/data pad drive |
| pad_ad_oe | output | 1 | Address/data pad output enable |
| pad_addr | output | ADDR_W | Address pads |
| pad_astb | output | 1 | Address strobe pad |
| pad_wr_n | output | 1 | Write strobe pad |
| pad_rd_n | output | 1 | Read strobe pad |
| pad_port | output | PORT_W | Port pads |
| core_wait_n | output | 1 | Wait request passed to the core |

## Verification
The assertions assume every input is synchronous to `clk`, holds no X after reset, and settles well before each rising edge. They also assume the request inputs are plain levels sampled once per edge; no pulse width is required. The bench changes all inputs only on the falling edge and samples outputs there too. Every mode change therefore follows from exactly one set of sampled inputs. Flags and masks are held for whole cycles, so live-source checks in the wake detector and the sequencer see the same value.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_WAIT = 2'd3
  } pmode_e;
endpackage

// File: rtl/stby_wake_detect.sv
module stby_wake_detect #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] STOP_WAKE_MASK = {{(NSRC-1){1'b1}}, 1'b0}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] irq_mask,
  output logic            any_live,
  output logic            stop_live
);
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] stop_ok;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign live[i] = irq_flag[i] & ~irq_mask[i];
    if (STOP_WAKE_MASK[i]) begin : g_can_stop
      assign stop_ok[i] = live[i];
    end else begin : g_no_stop
      assign stop_ok[i] = 1'b0;
    end
  end

  assign any_live  = |live;
  assign stop_live = |stop_ok;

  // a stop wake is always also a general wake
  p_stop_subset_r5: assert property (@(posedge clk) disable iff (rst)
    stop_live |-> any_live);
endmodule

// File: rtl/stby_ost_timer.sv
module stby_ost_timer #(
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int MAX_EXP = BASE_EXP + 2 * ((1 << SEL_W) - 1);
  localparam int CNT_W   = MAX_EXP;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [SEL_W-1:0] sel_q;
  int               shamt;

  always_comb begin
    shamt = CNT_W - BASE_EXP - 2 * int'(sel_q);
    limit = {CNT_W{1'b1}} >> shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      sel_q <= sel;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == limit);

  p_cnt_window_r6: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       halt_req,
  input  logic       on_main_clk,
  input  logic       any_live,
  input  logic       stop_live,
  input  logic       wait_done,
  output logic       wait_start,
  output logic       wait_run,
  output logic       stop_next,
  output logic       osc_en,
  output logic       cpu_clk_en,
  output logic       xtal_pullup,
  output logic [1:0] mode
);
  pmode_e mode_q, nxt;
  logic   from_stop_q, nxt_fs;
  logic   osc_q, cpu_q, pu_q;

  always_comb begin
    nxt    = mode_q;
    nxt_fs = from_stop_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (stop_req && on_main_clk) begin
          nxt    = any_live ? MODE_HALT : MODE_STOP;
          nxt_fs = 1'b1;
        end else if (halt_req) begin
          nxt    = MODE_HALT;
          nxt_fs = 1'b0;
        end
      end
      MODE_HALT: if (any_live) nxt = from_stop_q ? MODE_WAIT : MODE_RUN;
      MODE_STOP: if (stop_live) nxt = MODE_WAIT;
      MODE_WAIT: if (wait_done) nxt = MODE_RUN;
    endcase
  end

  assign wait_start = (nxt == MODE_WAIT) && (mode_q != MODE_WAIT);
  assign wait_run   = (mode_q == MODE_WAIT);
  assign stop_next  = (nxt == MODE_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_RUN;
      from_stop_q <= 1'b0;
      osc_q       <= 1'b1;
      cpu_q       <= 1'b1;
      pu_q        <= 1'b0;
    end else begin
      mode_q      <= nxt;
      from_stop_q <= nxt_fs;
      osc_q       <= (nxt != MODE_STOP);
      cpu_q       <= (nxt == MODE_RUN);
      pu_q        <= (nxt == MODE_STOP);
    end
  end

  assign mode        = mode_q;
  assign osc_en      = osc_q;
  assign cpu_clk_en  = cpu_q;
  assign xtal_pullup = pu_q;

  p_stop_needs_main_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && stop_req && !on_main_clk && !halt_req) |=> (mode_q == MODE_RUN));
  p_pullup_in_stop_r3: assert property (@(posedge clk) disable iff (rst)
    pu_q |-> (mode_q == MODE_STOP && !osc_q));
  p_halt_wake_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_HALT && !from_stop_q && any_live) |=> (mode_q == MODE_RUN));
  p_stop_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP) |=> (mode_q == MODE_STOP || mode_q == MODE_WAIT));
  p_wait_clocks_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WAIT) |-> (osc_q && !cpu_q));
  p_collapse_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && stop_req && on_main_clk && any_live) |=> (mode_q == MODE_HALT && osc_q && !pu_q));
  p_sleep_ignores_req_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP && !stop_live) |=> (mode_q == MODE_STOP));
endmodule

// File: rtl/stby_pin_guard.sv
module stby_pin_guard #(
  parameter int AD_W   = 8,
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_next,
  input  logic [AD_W-1:0]   cpu_ad_out,
  input  logic              cpu_ad_oe,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_astb,
  input  logic              cpu_wr_n,
  input  logic              cpu_rd_n,
  input  logic [PORT_W-1:0] cpu_port,
  input  logic              pad_wait_n,
  output logic [AD_W-1:0]   pad_ad_out,
  output logic              pad_ad_oe,
  output logic [ADDR_W-1:0] pad_addr,
  output logic              pad_astb,
  output logic              pad_wr_n,
  output logic              pad_rd_n,
  output logic [PORT_W-1:0] pad_port,
  output logic              core_wait_n
);
  logic in_stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_stop_q   <= 1'b0;
      pad_ad_out  <= '0;
      pad_ad_oe   <= 1'b0;
      pad_addr    <= '0;
      pad_astb    <= 1'b0;
      pad_wr_n    <= 1'b1;
      pad_rd_n    <= 1'b1;
      pad_port    <= '0;
      core_wait_n <= 1'b1;
    end else begin
      in_stop_q <= stop_next;
      if (stop_next) begin
        pad_ad_oe   <= 1'b0;
        pad_astb    <= 1'b0;
        pad_wr_n    <= 1'b1;
        pad_rd_n    <= 1'b1;
        core_wait_n <= 1'b1;
      end else begin
        pad_ad_out  <= cpu_ad_out;
        pad_ad_oe   <= cpu_ad_oe;
        pad_addr    <= cpu_addr;
        pad_astb    <= cpu_astb;
        pad_wr_n    <= cpu_wr_n;
        pad_rd_n    <= cpu_rd_n;
        pad_port    <= cpu_port;
        core_wait_n <= pad_wait_n;
      end
    end
  end

  p_idle_pins_r8: assert property (@(posedge clk) disable iff (rst)
    in_stop_q |-> (!pad_ad_oe && !pad_astb && pad_wr_n && pad_rd_n && core_wait_n));
  p_hold_latches_r9: assert property (@(posedge clk) disable iff (rst)
    (in_stop_q && $past(in_stop_q)) |-> ($stable(pad_addr) && $stable(pad_port)));
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl #(
  parameter int NSRC     = 8,
  parameter logic [NSRC-1:0] STOP_WAKE_MASK = {{(NSRC-1){1'b1}}, 1'b0},
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 12,
  parameter int AD_W     = 8,
  parameter int ADDR_W   = 16,
  parameter int PORT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              halt_req,
  input  logic              on_main_clk,
  input  logic [SEL_W-1:0]  ost_sel,
  input  logic [NSRC-1:0]   irq_flag,
  input  logic [NSRC-1:0]   irq_mask,
  input  logic [AD_W-1:0]   cpu_ad_out,
  input  logic              cpu_ad_oe,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_astb,
  input  logic              cpu_wr_n,
  input  logic              cpu_rd_n,
  input  logic [PORT_W-1:0] cpu_port,
  input  logic              pad_wait_n,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              xtal_pullup,
  output logic [1:0]        mode,
  output logic [AD_W-1:0]   pad_ad_out,
  output logic              pad_ad_oe,
  output logic [ADDR_W-1:0] pad_addr,
  output logic              pad_astb,
  output logic              pad_wr_n,
  output logic              pad_rd_n,
  output logic [PORT_W-1:0] pad_port,
  output logic              core_wait_n
);
  logic any_live, stop_live;
  logic wait_start, wait_run, wait_done, stop_next;

  stby_wake_detect #(.NSRC(NSRC), .STOP_WAKE_MASK(STOP_WAKE_MASK)) u_wake (
    .clk(clk), .rst(rst), .irq_flag(irq_flag), .irq_mask(irq_mask),
    .any_live(any_live), .stop_live(stop_live)
  );

  stby_ost_timer #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_timer (
    .clk(clk), .rst(rst), .start(wait_start), .run(wait_run),
    .sel(ost_sel), .done(wait_done)
  );

  stby_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_req), .halt_req(halt_req),
    .on_main_clk(on_main_clk), .any_live(any_live), .stop_live(stop_live),
    .wait_done(wait_done), .wait_start(wait_start), .wait_run(wait_run),
    .stop_next(stop_next), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .xtal_pullup(xtal_pullup), .mode(mode)
  );

  stby_pin_guard #(.AD_W(AD_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_pins (
    .clk(clk), .rst(rst), .stop_next(stop_next),
    .cpu_ad_out(cpu_ad_out), .cpu_ad_oe(cpu_ad_oe), .cpu_addr(cpu_addr),
    .cpu_astb(cpu_astb), .cpu_wr_n(cpu_wr_n), .cpu_rd_n(cpu_rd_n),
    .cpu_port(cpu_port), .pad_wait_n(pad_wait_n),
    .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe), .pad_addr(pad_addr),
    .pad_astb(pad_astb), .pad_wr_n(pad_wr_n), .pad_rd_n(pad_rd_n),
    .pad_port(pad_port), .core_wait_n(core_wait_n)
  );
endmodule

// File: tb/stby_wake_ctrl_tb.sv
`timescale 1ns/1ps
module stby_wake_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stop_req = 0, halt_req = 0, on_main_clk = 1;
  logic [2:0]  ost_sel = 0;
  logic [7:0]  irq_flag = 0, irq_mask = 8'hFF;
  logic [7:0]  cpu_ad_out = 0;
  logic        cpu_ad_oe = 0, cpu_astb = 0, cpu_wr_n = 1, cpu_rd_n = 1;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_port = 0;
  logic        pad_wait_n = 1;
  logic        osc_en, cpu_clk_en, xtal_pullup;
  logic [1:0]  mode;
  logic [7:0]  pad_ad_out, pad_port;
  logic        pad_ad_oe, pad_astb, pad_wr_n, pad_rd_n, core_wait_n;
  logic [15:0] pad_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  stby_wake_ctrl #(.BASE_EXP(2)) u_dut (
    .clk(clk), .rst(rst), .stop_req(stop_req), .halt_req(halt_req),
    .on_main_clk(on_main_clk), .ost_sel(ost_sel), .irq_flag(irq_flag),
    .irq_mask(irq_mask), .cpu_ad_out(cpu_ad_out), .cpu_ad_oe(cpu_ad_oe),
    .cpu_addr(cpu_addr), .cpu_astb(cpu_astb), .cpu_wr_n(cpu_wr_n),
    .cpu_rd_n(cpu_rd_n), .cpu_port(cpu_port), .pad_wait_n(pad_wait_n),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .xtal_pullup(xtal_pullup),
    .mode(mode), .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe),
    .pad_addr(pad_addr), .pad_astb(pad_astb), .pad_wr_n(pad_wr_n),
    .pad_rd_n(pad_rd_n), .pad_port(pad_port), .core_wait_n(core_wait_n)
  );

  typedef struct packed {
    logic       stop, halt, main;
    logic [7:0] flag, mask;
    logic [1:0] mode;
    logic [2:0] clks; // osc, cpu, pullup
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    {1'b0,1'b1,1'b1,8'h00,8'hFF,2'd1,3'b100},
    {1'b1,1'b0,1'b1,8'h00,8'hFF,2'd1,3'b100},
    {1'b0,1'b0,1'b1,8'h08,8'hFF,2'd1,3'b100},
    {1'b0,1'b0,1'b1,8'h08,8'hF7,2'd0,3'b110},
    {1'b1,1'b0,1'b0,8'h00,8'hFF,2'd0,3'b110},
    {1'b1,1'b1,1'b1,8'h00,8'hFF,2'd2,3'b001},
    {1'b0,1'b1,1'b1,8'h01,8'h00,2'd2,3'b001},
    {1'b0,1'b0,1'b1,8'h04,8'hFF,2'd2,3'b001},
    {1'b0,1'b0,1'b1,8'h04,8'hFB,2'd3,3'b100},
    {1'b0,1'b0,1'b1,8'h00,8'hFF,2'd3,3'b100},
    {1'b0,1'b0,1'b1,8'h00,8'hFF,2'd3,3'b100},
    {1'b1,1'b0,1'b1,8'h00,8'hFF,2'd3,3'b100},
    {1'b0,1'b0,1'b1,8'h00,8'hFF,2'd0,3'b110},
    {1'b0,1'b1,1'b1,8'h01,8'hFE,2'd1,3'b100},
    {1'b0,1'b0,1'b1,8'h01,8'h00,2'd0,3'b110},
    {1'b1,1'b0,1'b1,8'h10,8'h00,2'd1,3'b100},
    {1'b0,1'b0,1'b1,8'h10,8'h00,2'd3,3'b100},
    {1'b1,1'b1,1'b1,8'h00,8'hFF,2'd3,3'b100},
    {1'b0,1'b0,1'b1,8'h00,8'hFF,2'd3,3'b100},
    {1'b0,1'b0,1'b1,8'h00,8'hFF,2'd3,3'b100},
    {1'b0,1'b0,1'b1,8'h00,8'hFF,2'd0,3'b110}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R2";
      1, 6, 11, 17: return "R10";
      2, 3, 13, 14: return "R4";
      4, 5: return "R3";
      7, 8: return "R5";
      15, 16: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    stop_req = 0; halt_req = 0; irq_flag = 0; irq_mask = 8'hFF;
  endtask

  // count cycles spent in WAIT_STABLE, then expect RUN
  task automatic measure_wait(input string req, input int exp_len);
    int n = 0;
    while (mode == 2'd3 && n < 100000) begin
      step();
      n++;
    end
    chk(req, "wait length", n, exp_len);
    chk(req, "mode after wait", mode, 2'd0);
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    rst = 0;
    // R1 reset state
    chk("R1", "mode", mode, 2'd0);
    chk("R1", "osc_en", osc_en, 1'b1);
    chk("R1", "cpu_clk_en", cpu_clk_en, 1'b1);
    chk("R1", "xtal_pullup", xtal_pullup, 1'b0);
    chk("R1", "pad_wr_n", pad_wr_n, 1'b1);

    // vector walk, ost_sel=0 -> wait of 4 cycles
    for (int i = 0; i < NV; i++) begin
      stop_req = VEC[i].stop; halt_req = VEC[i].halt; on_main_clk = VEC[i].main;
      irq_flag = VEC[i].flag; irq_mask = VEC[i].mask;
      step();
      chk(vec_req(i), $sformatf("vec %0d mode", i), mode, VEC[i].mode);
      chk(vec_req(i), $sformatf("vec %0d clocks", i),
          {osc_en, cpu_clk_en, xtal_pullup}, VEC[i].clks);
    end
    idle_inputs();

    // R6 select sampled on entry: sel=1 -> 16, sel=2 -> 64
    for (int s = 1; s <= 2; s++) begin
      stop_req = 1; step(); stop_req = 0;
      chk("R3", "enter stop", mode, 2'd2);
      ost_sel = 3'(s); irq_flag = 8'h02; irq_mask = 8'h00;
      step();
      idle_inputs(); ost_sel = 0;
      chk("R6", "entered wait", mode, 2'd3);
      measure_wait("R6", (s == 1) ? 16 : 64);
    end

    // R8 / R9 pin behaviour
    cpu_addr = 16'hA5C3; cpu_port = 8'h3C; cpu_ad_oe = 1; cpu_ad_out = 8'h5A;
    cpu_astb = 1; cpu_wr_n = 0; cpu_rd_n = 0; pad_wait_n = 0;
    step();
    chk("R9", "addr passthrough", pad_addr, 16'hA5C3);
    chk("R9", "ad_oe passthrough", pad_ad_oe, 1'b1);
    stop_req = 1; step(); stop_req = 0;
    cpu_addr = 16'h1234; cpu_port = 8'hFF;
    step(); step();
    chk("R9", "addr held", pad_addr, 16'hA5C3);
    chk("R9", "port held", pad_port, 8'h3C);
    chk("R8", "idle pins", {pad_ad_oe, pad_astb, pad_wr_n, pad_rd_n, core_wait_n}, 5'b00111);
    irq_flag = 8'h80; irq_mask = 8'h00;
    step();
    idle_inputs();
    chk("R9", "addr follows after stop", pad_addr, 16'h1234);
    chk("R9", "wait pin follows after stop", core_wait_n, 1'b0);
    measure_wait("R6", 4);
    cpu_ad_oe = 0; cpu_astb = 0; cpu_wr_n = 1; cpu_rd_n = 1; pad_wait_n = 1;

    // R1 reset while stopped
    stop_req = 1; step(); stop_req = 0;
    chk("R3", "stopped before reset", xtal_pullup, 1'b1);
    rst = 1; step(); rst = 0;
    chk("R1", "mode after reset in stop", mode, 2'd0);
    chk("R1", "osc after reset in stop", osc_en, 1'b1);
    chk("R1", "pullup after reset in stop", xtal_pullup, 1'b0);
    chk("R1", "pins released", {pad_ad_oe, pad_wr_n, pad_rd_n}, 3'b011);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule